// File: doc/BRIEF.md
# Down-Spread Divide-Offset Generator

This block produces a slowly varying, non-negative offset that a fractional output divider adds to its nominal divide value. Because the offset only ever makes the divide ratio larger, the divided clock only ever slows down from its nominal frequency. The offset follows a symmetric triangle: it climbs in equal steps from zero to a peak, falls back to zero, and repeats. This spreads the output energy over a band below the nominal frequency and lowers its spectral peak.

The peak is set by a depth code that picks one of five spread levels, from 0.5 % to 2.5 % of the nominal divide value in 0.5 % steps. A rate code sets how long each step lasts, so that one triangle lasts one period of a modulation rate near 31.5 kHz. Spread is turned on by an enable pin. It is also gated by a flag that marks the output as fed from the second PLL; spread is never applied to such outputs. Settings are taken only when the triangle is at zero. A disable lets the current triangle finish before the offset parks at zero, so the divider never sees a step larger than one level.

Top module: `ssdn_modulator`

## Requirements
- R1: After a synchronous active-low reset, `spread_ofs` is 0 and `spread_vld` is 0. Whenever `spread_vld` is 0, `spread_ofs` is 0.
- R2: The offset is unsigned. It never exceeds the 2.5 % peak, and it never exceeds the peak of the depth in use. A divider that adds it can therefore only lower its output frequency.
- R3: The peak offset for `depth_sel` code k (k = 0..4) is floor(NOM_Q * (k+1) / 200), where NOM_Q = DIV_INT * 2^FRAC_W. Codes 5 to 7 use the 2.5 % peak.
- R4: While the block is sweeping, the level goes 0,1,…,N,N-1,…,1,0 and repeats, with N = 2^STEPS_LOG2. The offset is floor(level * peak / N), and the level changes by at most one per step.
- R5: Each level is held for D reference cycles, where D = round(REF_HZ / (2 * N * f)). `rate_sel` selects f: code 0 gives 30000 Hz, code 2 gives 33000 Hz, and codes 1 and 3 give 31500 Hz.
- R6: `depth_sel` and `rate_sel` are sampled only when a sweep starts from the parked state, or at the edge where the level returns to zero while spread stays active. A change made mid-triangle takes effect at the next triangle.
- R7: When spread becomes inactive mid-sweep, the triangle continues through its peak and down to zero. The block then parks with offset 0 and `spread_vld` 0, and stays there while spread is inactive.
- R8: While `src_pll_b` is 1, `ssen` has no effect: the block stays parked and `spread_vld` stays 0.
- R9: From the parked state, spread becomes active when `ssen`=1 and `src_pll_b`=0. `spread_vld` rises on the second rising edge after active is first sampled, with offset 0. The first step follows D cycles after that, and each later step follows D cycles after the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| depth_sel | input | 3 | Spread depth code (0 = 0.5 % … 4 = 2.5 %, 5 to 7 clamp) |
| rate_sel | input | 2 | Modulation rate code (0 = 30 kHz, 1 and 3 = 31.5 kHz, 2 = 33 kHz) |
| ssen | input | 1 | Spread enable, active high |
| src_pll_b | input | 1 | 1 = output fed from the second PLL, spread not allowed |
| spread_ofs | output | $clog2(DIV_INT+1)+FRAC_W | Divide-value offset, same fixed-point scale as the divider |
| spread_vld | output | 1 | High while a sweep is in progress |

## Verification
The bench builds the block with REF_HZ = 8 MHz and STEPS_LOG2 = 3, and keeps DIV_INT = 36 and FRAC_W = 10. The three rate codes then give dwells of 17, 16 and 15 cycles, which are distinct. A full triangle takes under 300 cycles, so every rate code, every depth code including the clamped ones, and several park and restart sequences fit in a short run. With these values the peaks are 184, 368, 552, 737 and 921. Several of these are not divisible by 8, so the truncation in level * peak / N is visible at individual steps, and an error in the dwell count shows up as a value sampled one cycle early or late.

// File: rtl/ssdn_pkg.sv
// Shared constants and elaboration-time helpers for the down-spread generator.
// Assumes: rates are given in Hz and depths in half-percent units.
package ssdn_pkg;

    localparam int RATE_LO_HZ   = 30000;
    localparam int RATE_NOM_HZ  = 31500;
    localparam int RATE_HI_HZ   = 33000;
    localparam int NUM_DEPTHS   = 5;
    localparam int DEPTH_CODE_W = 3;
    localparam int RATE_CODE_W  = 2;

    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    // Modulation rate in Hz selected by a rate code.
    function automatic int rate_hz(input int code);
        case (code)
            0:       return RATE_LO_HZ;
            2:       return RATE_HI_HZ;
            default: return RATE_NOM_HZ;
        endcase
    endfunction

    // Reference cycles per profile step, rounded to nearest, at least one.
    function automatic int dwell_cycles(input longint ref_hz, input int f_hz, input int steps);
        longint den;
        longint q;
        den = 2 * longint'(f_hz) * longint'(steps);
        q   = (ref_hz + den / 2) / den;
        if (q < 1) q = 1;
        return int'(q);
    endfunction

    // Peak offset for a depth code; codes past the last level clamp to it.
    function automatic int depth_peak(input longint nom_q, input int code);
        longint hp;
        hp = (code >= NUM_DEPTHS) ? longint'(NUM_DEPTHS) : longint'(code + 1);
        return int'((nom_q * hp) / 200);
    endfunction

endpackage

// File: rtl/ssdn_dwell_timer.sv
// Step timer: pulses tick once every dwell period while the sweep runs.
// Assumes: rate_code is held stable except at the edge where tick is high
// or where run rises, so each period is counted against one limit.
module ssdn_dwell_timer
    import ssdn_pkg::*;
#(
    parameter int REF_HZ     = 25_000_000,
    parameter int STEPS_LOG2 = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic [RATE_CODE_W-1:0] rate_code,
    output logic                   tick
);

    localparam int STEPS  = 1 << STEPS_LOG2;
    localparam int DW_MAX = dwell_cycles(longint'(REF_HZ), RATE_LO_HZ, STEPS);
    localparam int CNT_W  = $clog2(DW_MAX + 1);
    localparam int NCODES = 1 << RATE_CODE_W;

    logic [CNT_W-1:0] dwell_tbl [NCODES];
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    // One dwell constant per rate code, fixed at elaboration.
    for (genvar g = 0; g < NCODES; g++) begin : g_dwell
        assign dwell_tbl[g] = CNT_W'(dwell_cycles(longint'(REF_HZ), rate_hz(g), STEPS));
    end

    assign limit = dwell_tbl[rate_code];
    assign tick  = run && (cnt == limit - CNT_W'(1));

    // Counts reference cycles within one step; clears while idle or on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R5: the count never passes the dwell limit in force.
    p_dwell_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));

    // R5: an idle timer holds zero.
    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (cnt == '0));

endmodule

// File: rtl/ssdn_tri_profile.sv
// Triangle sequencer: walks an up/down level between 0 and 2^STEPS_LOG2.
// It starts from park when active, samples settings at level zero, and
// finishes a triangle before parking when active drops.
// Assumes: tick is a single-cycle pulse, only while running.
module ssdn_tri_profile
    import ssdn_pkg::*;
#(
    parameter int STEPS_LOG2 = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic                    tick,
    input  logic [DEPTH_CODE_W-1:0] depth_in,
    input  logic [RATE_CODE_W-1:0]  rate_in,
    output logic                    running,
    output logic [STEPS_LOG2:0]     level,
    output logic [DEPTH_CODE_W-1:0] depth_q,
    output logic [RATE_CODE_W-1:0]  rate_q
);

    localparam int STEPS = 1 << STEPS_LOG2;
    localparam int LVL_W = STEPS_LOG2 + 1;

    sweep_dir_e dir;

    // Sequences start, climb, fall, endpoint resampling and park.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            level   <= '0;
            dir     <= SWEEP_UP;
            depth_q <= '0;
            rate_q  <= '0;
        end else if (!running) begin
            if (active) begin
                running <= 1'b1;
                dir     <= SWEEP_UP;
                depth_q <= depth_in;
                rate_q  <= rate_in;
            end
        end else if (tick) begin
            if (dir == SWEEP_UP) begin
                level <= level + LVL_W'(1);
                if (level == LVL_W'(STEPS - 1)) dir <= SWEEP_DOWN;
            end else begin
                level <= level - LVL_W'(1);
                if (level == LVL_W'(1)) begin
                    dir <= SWEEP_UP;
                    if (active) begin
                        depth_q <= depth_in;
                        rate_q  <= rate_in;
                    end else begin
                        running <= 1'b0;
                    end
                end
            end
        end
    end

    // R7: a parked sequencer sits at level zero.
    p_park_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (level == '0));

    // R4: level never passes the peak.
    p_peak_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(STEPS));

    // R4: one step per update at most.
    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + LVL_W'(1))
        || ($past(level) == level + LVL_W'(1)));

    // R6: settings stay put away from the zero endpoint.
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level) != '0) && (level != '0) |-> $stable(depth_q) && $stable(rate_q));

endmodule

// File: rtl/ssdn_depth_scale.sv
// Depth scaler: maps the level to an offset, floor(level * peak / N),
// and registers it together with the valid flag.
// Assumes: depth_code changes only when level is zero.
module ssdn_depth_scale
    import ssdn_pkg::*;
#(
    parameter int STEPS_LOG2 = 4,
    parameter int DIV_INT    = 36,
    parameter int FRAC_W     = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                running,
    input  logic [STEPS_LOG2:0]                 level,
    input  logic [DEPTH_CODE_W-1:0]             depth_code,
    output logic [$clog2(DIV_INT+1)+FRAC_W-1:0] ofs,
    output logic                                ofs_vld
);

    localparam int     OFS_W  = $clog2(DIV_INT + 1) + FRAC_W;
    localparam int     LVL_W  = STEPS_LOG2 + 1;
    localparam int     PROD_W = OFS_W + LVL_W;
    localparam longint NOM_Q  = longint'(DIV_INT) << FRAC_W;
    localparam int     NCODES = 1 << DEPTH_CODE_W;
    localparam int     PK_TOP = depth_peak(NOM_Q, NUM_DEPTHS - 1);

    logic [OFS_W-1:0]  peak_tbl [NCODES];
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    // Peak per depth code, clamped codes included.
    for (genvar g = 0; g < NCODES; g++) begin : g_peak
        assign peak_tbl[g] = OFS_W'(depth_peak(NOM_Q, g));
    end

    assign prod   = PROD_W'(level) * PROD_W'(peak_tbl[depth_code]);
    assign scaled = prod >> STEPS_LOG2;

    // Registers the scaled offset and the sweep flag for the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs     <= '0;
            ofs_vld <= 1'b0;
        end else begin
            ofs     <= OFS_W'(scaled);
            ofs_vld <= running;
        end
    end

    // R2: the offset stays at or below the deepest peak.
    p_ofs_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ofs <= OFS_W'(PK_TOP));

    // R1: no offset leaves the block outside a sweep.
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_vld |-> (ofs == '0));

endmodule

// File: rtl/ssdn_modulator.sv
// Down-spread offset generator top: gates spread by enable pin and
// source flag, and joins the step timer, triangle sequencer and scaler.
// Assumes: all inputs are synchronous to clk.
module ssdn_modulator
    import ssdn_pkg::*;
#(
    parameter int REF_HZ     = 25_000_000,
    parameter int STEPS_LOG2 = 4,
    parameter int DIV_INT    = 36,
    parameter int FRAC_W     = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [2:0]                          depth_sel,
    input  logic [1:0]                          rate_sel,
    input  logic                                ssen,
    input  logic                                src_pll_b,
    output logic [$clog2(DIV_INT+1)+FRAC_W-1:0] spread_ofs,
    output logic                                spread_vld
);

    logic                    active;
    logic                    tick;
    logic                    running;
    logic [STEPS_LOG2:0]     level;
    logic [DEPTH_CODE_W-1:0] depth_q;
    logic [RATE_CODE_W-1:0]  rate_q;

    // Spread is allowed only on first-PLL outputs with the pin high.
    assign active = ssen && !src_pll_b;

    ssdn_dwell_timer #(
        .REF_HZ     (REF_HZ),
        .STEPS_LOG2 (STEPS_LOG2)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .rate_code (rate_q),
        .tick      (tick)
    );

    ssdn_tri_profile #(
        .STEPS_LOG2 (STEPS_LOG2)
    ) u_profile (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (tick),
        .depth_in (depth_sel),
        .rate_in  (rate_sel),
        .running  (running),
        .level    (level),
        .depth_q  (depth_q),
        .rate_q   (rate_q)
    );

    ssdn_depth_scale #(
        .STEPS_LOG2 (STEPS_LOG2),
        .DIV_INT    (DIV_INT),
        .FRAC_W     (FRAC_W)
    ) u_scale (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .level      (level),
        .depth_code (depth_q),
        .ofs        (spread_ofs),
        .ofs_vld    (spread_vld)
    );

    // R8: a second-PLL source keeps the block parked.
    p_pllb_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !running && src_pll_b |=> !running);

    // R9: the valid flag trails the sequencer by one register.
    p_vld_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |=> spread_vld);

endmodule

// File: tb/test_ssdn_modulator.sv
// Directed bench: one task per scenario, each checking its own results.
module test_ssdn_modulator;

    localparam int REF_HZ = 8_000_000;
    localparam int SL2    = 3;
    localparam int N      = 1 << SL2;
    localparam int DIVI   = 36;
    localparam int FW     = 10;
    localparam int OW     = $clog2(DIVI + 1) + FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    depth_sel = '0;
    logic [1:0]    rate_sel = '0;
    logic          ssen = 1'b0;
    logic          src_pll_b = 1'b0;
    logic [OW-1:0] spread_ofs;
    logic          spread_vld;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    ssdn_modulator #(
        .REF_HZ     (REF_HZ),
        .STEPS_LOG2 (SL2),
        .DIV_INT    (DIVI),
        .FRAC_W     (FW)
    ) i_ssdn_modulator (
        .clk        (clk),
        .rst_n      (rst_n),
        .depth_sel  (depth_sel),
        .rate_sel   (rate_sel),
        .ssen       (ssen),
        .src_pll_b  (src_pll_b),
        .spread_ofs (spread_ofs),
        .spread_vld (spread_vld)
    );

    function automatic int exp_dwell(input int code);
        int f;
        f = (code == 0) ? 30000 : (code == 2) ? 33000 : 31500;
        return (REF_HZ + N * f) / (2 * N * f);
    endfunction

    function automatic int exp_peak(input int code);
        int hp;
        hp = (code > 4) ? 5 : code + 1;
        return ((DIVI * 1024) * hp) / 200;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Holds for dwell-1 cycles at the old value, then expects the new one.
    task automatic step_check(input int lvl, input int pk, input int dw, input int prev,
                              input string req);
        repeat (dw - 1) @(negedge clk);
        check_eq({req, " R5 hold"}, int'(spread_ofs), prev);
        @(negedge clk);
        check_eq({req, " R4 level"}, int'(spread_ofs), (lvl * pk) / N);
    endtask

    // Walks one full triangle from zero; drops ssen after step drop_at (0 = never).
    task automatic run_triangle(input int pk, input int dw, input int drop_at, input string req);
        int prev = 0;
        for (int i = 1; i <= 2 * N; i++) begin
            int lvl = (i <= N) ? i : 2 * N - i;
            step_check(lvl, pk, dw, prev, req);
            if (i == N) begin
                check_eq({req, " R3 peak"}, int'(spread_ofs), pk);
                check_eq({req, " R2 bound"}, int'(spread_ofs <= OW'(exp_peak(4))), 1);
            end
            prev = (lvl * pk) / N;
            if (i == drop_at) ssen = 1'b0;
        end
    endtask

    task automatic wait_start(input string req);
        int n = 0;
        while (!spread_vld && n < 50) begin
            @(negedge clk);
            n++;
        end
        check_eq({req, " R9 start latency"}, n, 2);
        check_eq({req, " R9 start offset"}, int'(spread_ofs), 0);
    endtask

    task automatic check_parked(input int cycles, input string req);
        int bad = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (spread_vld || spread_ofs != '0) bad++;
        end
        check_eq({req, " parked cycles with activity"}, bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset offset", int'(spread_ofs), 0);
        check_eq("R1 reset valid", int'(spread_vld), 0);
        rst_n = 1'b1;
        check_parked(20, "R1 idle");
    endtask

    // R4/R7: full sweep, then a disable mid-rise that completes the triangle.
    task automatic t_basic();
        depth_sel = 3'd2;
        rate_sel  = 2'd1;
        ssen      = 1'b1;
        wait_start("basic");
        run_triangle(exp_peak(2), exp_dwell(1), 0, "basic tri1");
        check_eq("R4 valid across endpoint", int'(spread_vld), 1);
        run_triangle(exp_peak(2), exp_dwell(1), 3, "basic tri2 R7");
        check_eq("R7 parked valid", int'(spread_vld), 0);
        check_eq("R7 parked offset", int'(spread_ofs), 0);
        check_parked(3 * exp_dwell(1), "R7 stay");
    endtask

    // R3/R5: each depth and rate code including clamped depth codes.
    task automatic t_codes(input int d, input int r);
        depth_sel = 3'(d);
        rate_sel  = 2'(r);
        ssen      = 1'b1;
        wait_start("codes");
        run_triangle(exp_peak(d), exp_dwell(r), 1, $sformatf("R3 d%0d r%0d", d, r));
        check_eq("R7 park after codes", int'(spread_vld), 0);
        @(negedge clk);
    endtask

    // R6: settings changed mid-triangle wait for the zero endpoint.
    task automatic t_latch();
        depth_sel = 3'd1;
        rate_sel  = 2'd1;
        ssen      = 1'b1;
        wait_start("latch");
        depth_sel = 3'd3;
        rate_sel  = 2'd2;
        run_triangle(exp_peak(1), exp_dwell(1), 0, "R6 old settings");
        run_triangle(exp_peak(3), exp_dwell(2), 1, "R6 new settings");
        check_eq("R6 park", int'(spread_vld), 0);
        @(negedge clk);
    endtask

    // R8: second-PLL source ignores the enable pin.
    task automatic t_pllb();
        depth_sel = 3'd4;
        rate_sel  = 2'd1;
        src_pll_b = 1'b1;
        ssen      = 1'b1;
        check_parked(2 * N * exp_dwell(1) + 10, "R8 pll b");
        src_pll_b = 1'b0;
        wait_start("R8 release");
        run_triangle(exp_peak(4), exp_dwell(1), 1, "R8 after release");
        check_eq("R8 park", int'(spread_vld), 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_codes(0, 0);
        t_codes(4, 2);
        t_codes(6, 3);
        t_codes(3, 0);
        t_latch();
        t_pllb();
        summary();
        $finish;
    end

endmodule